// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block runs the handshake for one latched data port that sits between a processor and a peripheral. In strobed-input mode the peripheral pulls its strobe low to capture the port pins into an input latch. The controller then raises a buffer-full flag and, when interrupts are enabled, requests service on the strobe's rising edge. A processor read empties the latch.

In strobed-output mode a processor write fills the output latch and pulls an active-low buffer-full line. The peripheral's acknowledge pulse returns that line high. The end of the pulse raises an interrupt so that the processor can send the next byte.

A parameter decides whether the instance can also run bidirectionally. The full group uses it. The reduced group sets it off and treats the bidirectional mode code as output. In bidirectional mode both handshakes run at once, and the port's output drivers are enabled only while acknowledge is held low. Strobe and acknowledge come from another clock domain, so each passes through a two-flop synchroniser before its edges are detected.

Top module: `strobed_port_ctrl`

## Requirements
- R1: After reset the input buffer-full flag `ibf` is 0, `obf_n` is 1, `intr` is 0 and the input latch reads 0.
- R2: Mode code 2'b00 (and 2'b11) is strobed input. A falling edge of `stb_n` loads `pin_in` into the input latch and sets `ibf`. `cpu_rdata` then holds that value even after `pin_in` changes.
- R3: In input mode a rising edge of `stb_n` while `ibf` is 1 sets `intr` only if `int_en` is 1. With `int_en` at 0, `intr` stays 0.
- R4: In input or bidirectional mode a one-cycle `cpu_rd` clears `ibf` and the input interrupt.
- R5: Mode code 2'b01 is strobed output. A one-cycle `cpu_wr` loads `cpu_wdata` onto `pin_out`, drives `obf_n` to 0 and clears the output interrupt.
- R6: A falling edge of `ack_n` returns `obf_n` to 1.
- R7: A rising edge of `ack_n` while `obf_n` is 1 sets `intr` if `int_en` is 1. It leaves `intr` at 0 if `int_en` is 0.
- R8: `pin_oe` is 1 in output mode and 0 in input mode. In bidirectional mode (code 2'b10) it equals the inverse of the raw `ack_n`, with no synchroniser delay.
- R9: The block acts on a change of `stb_n` or `ack_n` on the third rising clock edge after the change, and not before.
- R10: In bidirectional mode `intr` is the OR of the input and output requests. A read clears only the input request and a write clears only the output request.
- R11: With `BIDIR_EN` = 0, mode code 2'b10 behaves as output mode, so `pin_oe` stays 1 while `ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00/11 input, 01 output, 10 bidirectional |
| int_en | input | 1 | Interrupt enable |
| cpu_wr | input | 1 | One-cycle write strobe for the output latch |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rd | input | 1 | One-cycle read strobe for the input latch |
| cpu_rdata | output | DATA_W | Input latch contents |
| pin_in | input | DATA_W | Port pins sampled on strobe |
| pin_out | output | DATA_W | Output latch driven to the pins |
| pin_oe | output | 1 | Output driver enable for the tristate pins |
| stb_n | input | 1 | Peripheral strobe, active low |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| ibf | output | 1 | Input buffer full, active high |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request, active high |

## Verification
The input path is tried with all-zero, all-one, alternating and nibble-pattern bytes, with the interrupt enable both on and off. These bytes expose stuck, swapped or shifted data bits in the latch, and show that the enable gates only the interrupt and not the buffer-full flag. The output path is given the same kinds of bytes, which tells apart a correct latch from one that passes the pins through or misses the acknowledge edge. Directed cases then count the exact synchroniser delay, check that `pin_oe` follows the raw acknowledge in bidirectional mode, and confirm that a read or a write each withdraws only its own half of the interrupt.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [1:0] {
    HS_IN    = 2'b00,
    HS_OUT   = 2'b01,
    HS_BIDIR = 2'b10,
    HS_IN2   = 2'b11
  } hs_mode_e;

  function automatic hs_mode_e eff_mode(input logic [1:0] m, input bit bidir_ok);
    case (m)
      2'b01:   return HS_OUT;
      2'b10:   return bidir_ok ? HS_BIDIR : HS_OUT;
      default: return HS_IN;
    endcase
  endfunction

  function automatic logic in_active(input hs_mode_e m);
    return (m == HS_IN) || (m == HS_BIDIR);
  endfunction

  function automatic logic out_active(input hs_mode_e m);
    return (m == HS_OUT) || (m == HS_BIDIR);
  endfunction

  // set has priority over clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

  // active-low full flag: a write empties nothing, it fills; ack empties
  function automatic logic obf_n_next(input logic cur, input logic wr, input logic ack_fall);
    if (wr) return 1'b0;
    if (ack_fall) return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din_n,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din_n};
      prev  <= chain[STAGES-1];
    end
  end

  assign fall = prev & ~chain[STAGES-1];
  assign rise = ~prev & chain[STAGES-1];
endmodule

// File: rtl/hs_in_path.sv
module hs_in_path import hs_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              int_en,
  input  logic              stb_fall,
  input  logic              stb_rise,
  input  logic              rd,
  input  logic [DATA_W-1:0] pins,
  output logic [DATA_W-1:0] latch_q,
  output logic              ibf_q,
  output logic              intr_q
);
  logic load, clr, set_int;

  assign load    = en & stb_fall;
  assign clr     = en & rd;
  assign set_int = en & stb_rise & ibf_q & int_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      ibf_q   <= 1'b0;
      intr_q  <= 1'b0;
    end else begin
      if (load) latch_q <= pins;
      ibf_q  <= flag_next(ibf_q, load, clr);
      intr_q <= flag_next(intr_q, set_int, clr);
    end
  end
endmodule

// File: rtl/hs_out_path.sv
module hs_out_path import hs_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              int_en,
  input  logic              ack_fall,
  input  logic              ack_rise,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] latch_q,
  output logic              obf_n_q,
  output logic              intr_q
);
  logic do_wr, set_int;

  assign do_wr   = en & wr;
  assign set_int = en & ack_rise & obf_n_q & int_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      obf_n_q <= 1'b1;
      intr_q  <= 1'b0;
    end else begin
      if (do_wr) latch_q <= wdata;
      obf_n_q <= obf_n_next(obf_n_q, do_wr, en & ack_fall);
      intr_q  <= flag_next(intr_q, set_int, do_wr);
    end
  end
endmodule

// File: rtl/strobed_port_ctrl.sv
module strobed_port_ctrl import hs_pkg::*; #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit BIDIR_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              int_en,
  input  logic              cpu_wr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [DATA_W-1:0] pin_in,
  output logic [DATA_W-1:0] pin_out,
  output logic              pin_oe,
  input  logic              stb_n,
  input  logic              ack_n,
  output logic              ibf,
  output logic              obf_n,
  output logic              intr
);
  hs_mode_e mode_eff;
  logic     in_en, out_en;
  logic     stb_fall, stb_rise, ack_fall, ack_rise;
  logic     intr_in, intr_out;

  assign mode_eff = eff_mode(mode, BIDIR_EN);
  assign in_en    = in_active(mode_eff);
  assign out_en   = out_active(mode_eff);

  hs_sync_edge #(.STAGES(SYNC_STAGES)) u_stb (
    .clk(clk), .rst_n(rst_n), .din_n(stb_n), .fall(stb_fall), .rise(stb_rise));

  hs_sync_edge #(.STAGES(SYNC_STAGES)) u_ack (
    .clk(clk), .rst_n(rst_n), .din_n(ack_n), .fall(ack_fall), .rise(ack_rise));

  hs_in_path #(.DATA_W(DATA_W)) u_in (
    .clk(clk), .rst_n(rst_n), .en(in_en), .int_en(int_en),
    .stb_fall(stb_fall), .stb_rise(stb_rise), .rd(cpu_rd), .pins(pin_in),
    .latch_q(cpu_rdata), .ibf_q(ibf), .intr_q(intr_in));

  hs_out_path #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .en(out_en), .int_en(int_en),
    .ack_fall(ack_fall), .ack_rise(ack_rise), .wr(cpu_wr), .wdata(cpu_wdata),
    .latch_q(pin_out), .obf_n_q(obf_n), .intr_q(intr_out));

  always_comb begin
    case (mode_eff)
      HS_OUT:   pin_oe = 1'b1;
      HS_BIDIR: pin_oe = ~ack_n;
      default:  pin_oe = 1'b0;
    endcase
  end

  assign intr = (in_en & intr_in) | (out_en & intr_out);
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk import hs_pkg::*; (
  input logic     clk,
  input logic     rst_n,
  input hs_mode_e mode_eff,
  input logic     in_en,
  input logic     out_en,
  input logic     int_en,
  input logic     cpu_wr,
  input logic     cpu_rd,
  input logic     ack_n,
  input logic     stb_fall,
  input logic     ack_fall,
  input logic     ibf,
  input logic     obf_n,
  input logic     intr,
  input logic     pin_oe
);
  // R5
  wr_fills_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && cpu_wr) |=> !obf_n);

  // R4
  rd_empties_ibf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_en && cpu_rd && !stb_fall) |=> !ibf);

  // R6
  ack_empties_obf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && ack_fall && !cpu_wr) |=> obf_n);

  // R3
  intr_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr) |-> $past(int_en));

  // R8
  in_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == HS_IN) |-> !pin_oe);

  // R8
  bidir_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == HS_BIDIR && ack_n) |-> !pin_oe);
endmodule

bind strobed_port_ctrl hs_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode_eff(mode_eff), .in_en(in_en), .out_en(out_en),
  .int_en(int_en), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .ack_n(ack_n),
  .stb_fall(stb_fall), .ack_fall(ack_fall), .ibf(ibf), .obf_n(obf_n),
  .intr(intr), .pin_oe(pin_oe));

// File: tb/tb_strobed_port_ctrl.sv
module tb_strobed_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [1:0] mode_b = 2'b10;
  logic       int_en = 1'b0;
  logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [7:0] cpu_wdata = '0, pin_in = '0;
  logic       stb_n = 1'b1, ack_n = 1'b1;
  logic [7:0] cpu_rdata, pin_out, rdata_b, pout_b;
  logic       pin_oe, ibf, obf_n, intr;
  logic       oe_b, ibf_b, obf_b, intr_b;
  int         tests = 0, fails = 0;

  always #10 clk = ~clk;

  strobed_port_ctrl dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .int_en(int_en), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .stb_n(stb_n), .ack_n(ack_n),
    .ibf(ibf), .obf_n(obf_n), .intr(intr));

  strobed_port_ctrl #(.BIDIR_EN(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .mode(mode_b), .int_en(int_en), .cpu_wr(1'b0),
    .cpu_wdata(cpu_wdata), .cpu_rd(1'b0), .cpu_rdata(rdata_b), .pin_in(pin_in),
    .pin_out(pout_b), .pin_oe(oe_b), .stb_n(1'b1), .ack_n(ack_n),
    .ibf(ibf_b), .obf_n(obf_b), .intr(intr_b));

  // {int_en, data}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'hA5},
    {1'b1, 8'h5A}, {1'b0, 8'h3C}, {1'b1, 8'hC3}};

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    rst_n = 1'b0; mode = m; stb_n = 1'b1; ack_n = 1'b1; cpu_wr = 0; cpu_rd = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic strobe_pulse();
    stb_n = 1'b0; step(3); stb_n = 1'b1; step(3);
  endtask

  task automatic ack_pulse();
    ack_n = 1'b0; step(3); ack_n = 1'b1; step(3);
  endtask

  task automatic rd_pulse();
    cpu_rd = 1'b1; step(1); cpu_rd = 1'b0;
  endtask

  task automatic wr_pulse(input logic [7:0] d);
    cpu_wdata = d; cpu_wr = 1'b1; step(1); cpu_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset(2'b00);
    // R1 reset state
    check("R1 ibf", ibf, 0);
    check("R1 obf_n", obf_n, 1);
    check("R1 intr", intr, 0);
    check("R1 rdata", cpu_rdata, 0);

    // R2 R3 R4 table walk in input mode
    for (int i = 0; i < 6; i++) begin
      pin_in = VEC[i][7:0]; int_en = VEC[i][8];
      strobe_pulse();
      pin_in = ~VEC[i][7:0];
      check("R2 latched data", cpu_rdata, VEC[i][7:0]);
      check("R2 ibf set", ibf, 1);
      check("R3 intr gated by int_en", intr, VEC[i][8]);
      rd_pulse();
      check("R4 ibf cleared", ibf, 0);
      check("R4 intr cleared", intr, 0);
      check("R8 input oe off", pin_oe, 0);
    end

    // R9 synchroniser latency on stb_n
    pin_in = 8'h96; int_en = 1'b1;
    stb_n = 1'b0; step(2);
    check("R9 not before third edge", ibf, 0);
    step(1);
    check("R9 on third edge", ibf, 1);
    stb_n = 1'b1; step(3);
    rd_pulse();

    // R5 R6 R7 output mode table walk
    do_reset(2'b01);
    check("R8 output oe on", pin_oe, 1);
    for (int i = 0; i < 6; i++) begin
      int_en = VEC[i][8];
      wr_pulse(VEC[i][7:0]);
      check("R5 pin_out", pin_out, VEC[i][7:0]);
      check("R5 obf_n low", obf_n, 0);
      check("R5 intr cleared by write", intr, 0);
      ack_n = 1'b0; step(2);
      check("R9 ack not before third edge", obf_n, 0);
      step(1);
      check("R6 obf_n high after ack fall", obf_n, 1);
      ack_n = 1'b1; step(3);
      check("R7 intr after ack rise", intr, VEC[i][8]);
    end
    wr_pulse(8'h11);
    check("R5 write clears intr", intr, 0);

    // R8 R10 bidirectional
    do_reset(2'b10);
    int_en = 1'b1;
    check("R8 bidir oe off with ack high", pin_oe, 0);
    wr_pulse(8'h77);
    ack_n = 1'b0; #1;
    check("R8 bidir oe follows raw ack", pin_oe, 1);
    step(3); ack_n = 1'b1; #1;
    check("R8 bidir oe off after ack", pin_oe, 0);
    step(3);
    check("R10 output request", intr, 1);
    pin_in = 8'h2D; strobe_pulse();
    check("R10 input latched", cpu_rdata, 8'h2D);
    rd_pulse();
    check("R10 read keeps output request", intr, 1);
    check("R10 read clears ibf", ibf, 0);
    strobe_pulse();
    wr_pulse(8'h88);
    check("R10 write keeps input request", intr, 1);
    rd_pulse();
    check("R10 both cleared", intr, 0);

    // R11 reduced group: code 10 acts as output
    check("R11 oe stays on with ack high", oe_b, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule